// File: doc/BRIEF.md
# Per-Source Sensing Interrupt Controller

This block collects up to 51 interrupt sources and presents two requests to a processor: a normal interrupt and a fast interrupt. Software sets, for each source, whether the line is watched as a level or as an edge. It also sets whether one or both edges count, which polarity is active, and which of the two requests the source feeds. Inputs are asynchronous to the block clock and pass through a synchronizer before any decision is made.

Software uses a flat word-addressed register port. It can write the configuration masks and read the synchronized input levels, the raw status and the enabled (pending) status. It can also acknowledge latched edges and raise any source by software. Each request output is the OR of the sources that are enabled, pending and routed to it. Vector generation and priority ordering are left to logic outside the block.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset all configuration masks, the enable mask and every raw status bit are 0, and both `irq_o` and `fiq_o` are low.
- R2: Each input passes through a two-stage synchronizer. A change driven before rising edge k appears in the level register (address 2) after edge k+1, and in the raw status (address 0) after edge k+2.
- R3: With its sense bit (address 3) at 1, a source is level sensed. Its raw bit equals the synchronized input when its polarity bit (address 5) is 1, and the inverted input when the polarity bit is 0. Writes to the edge-clear register do not change it.
- R4: With its sense bit at 0 and its dual bit (address 4) at 0, a source latches its raw bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0.
- R5: With its sense bit at 0 and its dual bit at 1, a source latches its raw bit on both rising and falling edges, whatever its polarity bit.
- R6: Writing 1 to a bit of the edge-clear register (address 9) clears that latched edge-sensed raw bit. A latched bit that is not cleared stays set. If an edge on the same source is detected in the same cycle as the clear, the bit stays set.
- R7: Writing 1 to a bit of the software-trigger register (address 10) sets that raw bit on the write's clock edge.
- R8: The enable mask reads at address 7 or 8. Writing 1 at address 7 sets enable bits and writing 1 at address 8 clears them; writing 0 bits at either address has no effect. A disabled source still updates its raw bit but drives no output.
- R9: `irq_o` is the OR of raw AND enable over sources whose route bit (address 6) is 0. `fiq_o` is the same OR over sources whose route bit is 1.
- R10: The pending register (address 1) reads raw AND enable.
- R11: Read-data bits 51 to 63 are always 0, and writes to those bit positions are ignored.
- R12: The register map by 4-bit word address: 0 raw, 1 pending, 2 level, 3 sense, 4 dual, 5 polarity, 6 route, 7 enable-set, 8 enable-clear, 9 edge-clear, 10 software-trigger. Addresses 9, 10 and 11 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 51 | Asynchronous interrupt source lines |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
An edge on a source can be detected in the same cycle in which software writes that source's bit in the edge-clear register. The bench first latches the bit by software trigger. It then drives a rising input so that the synchronized edge lands in the same cycle as the clear write. The raw bit is judged to survive, and a later clear without an edge is judged to remove it. A second overlap, a clear write against level-sensed sources during a sweep over all eight sense, dual and polarity combinations, must leave their bits untouched.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_RAW    = 4'd0,
    A_PEND   = 4'd1,
    A_LVL    = 4'd2,
    A_SENSE  = 4'd3,
    A_DUAL   = 4'd4,
    A_POL    = 4'd5,
    A_ROUTE  = 4'd6,
    A_EN_SET = 4'd7,
    A_EN_CLR = 4'd8,
    A_CLR    = 4'd9,
    A_TRIG   = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 51,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned N = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] dual_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] raw_q;
  logic [N-1:0] raw_d;
  logic [N-1:0] rise;
  logic [N-1:0] fall;
  logic [N-1:0] hit;
  logic [N-1:0] active;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign rise[g]   = lvl_i[g] & ~prev_q[g];
    assign fall[g]   = ~lvl_i[g] & prev_q[g];
    assign hit[g]    = dual_i[g] ? (rise[g] | fall[g])
                                 : (pol_i[g] ? rise[g] : fall[g]);
    assign active[g] = ~(lvl_i[g] ^ pol_i[g]);
    // Set (edge or trigger) takes precedence over a same-cycle clear.
    assign raw_d[g]  = sense_i[g] ? (active[g] | trig_i[g])
                                  : ((raw_q[g] & ~clr_i[g]) | hit[g] | trig_i[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      raw_q  <= raw_d;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      lvl_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      dual_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      route_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      trig_o
);
  reg_addr_e    sel;
  logic [N-1:0] wbits;
  logic [N-1:0] sense_q, sense_d;
  logic [N-1:0] dual_q, dual_d;
  logic [N-1:0] pol_q, pol_d;
  logic [N-1:0] route_q, route_d;
  logic [N-1:0] en_q, en_d;
  logic         cfg_ce;
  logic [N-1:0] rd_bits;

  assign sel    = reg_addr_e'(addr_i);
  assign wbits  = wdata_i[N-1:0];
  assign cfg_ce = we_i;

  always_comb begin
    sense_d = sense_q;
    dual_d  = dual_q;
    pol_d   = pol_q;
    route_d = route_q;
    en_d    = en_q;
    unique case (sel)
      A_SENSE:  sense_d = wbits;
      A_DUAL:   dual_d  = wbits;
      A_POL:    pol_d   = wbits;
      A_ROUTE:  route_d = wbits;
      A_EN_SET: en_d    = en_q | wbits;
      A_EN_CLR: en_d    = en_q & ~wbits;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
      route_q <= '0;
      en_q    <= '0;
    end else if (cfg_ce) begin
      sense_q <= sense_d;
      dual_q  <= dual_d;
      pol_q   <= pol_d;
      route_q <= route_d;
      en_q    <= en_d;
    end
  end

  assign clr_o  = (we_i && sel == A_CLR)  ? wbits : '0;
  assign trig_o = (we_i && sel == A_TRIG) ? wbits : '0;

  always_comb begin
    rd_bits = '0;
    unique case (sel)
      A_RAW:    rd_bits = raw_i;
      A_PEND:   rd_bits = raw_i & en_q;
      A_LVL:    rd_bits = lvl_i;
      A_SENSE:  rd_bits = sense_q;
      A_DUAL:   rd_bits = dual_q;
      A_POL:    rd_bits = pol_q;
      A_ROUTE:  rd_bits = route_q;
      A_EN_SET: rd_bits = en_q;
      A_EN_CLR: rd_bits = en_q;
      default:  rd_bits = '0;
    endcase
  end

  assign rdata_o = REG_W'(rd_bits);
  assign sense_o = sense_q;
  assign dual_o  = dual_q;
  assign pol_o   = pol_q;
  assign route_o = route_q;
  assign en_o    = en_q;
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 51,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [1:0]         rst_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] sense;
  logic [NUM_SRC-1:0] dual;
  logic [NUM_SRC-1:0] pol;
  logic [NUM_SRC-1:0] route;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] trig;
  logic [NUM_SRC-1:0] live;

  // Reset asserts at once and deasserts after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  irq_detect #(.N(NUM_SRC)) u_detect (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lvl_i   (lvl),
    .sense_i (sense),
    .dual_i  (dual),
    .pol_i   (pol),
    .clr_i   (clr),
    .trig_i  (trig),
    .raw_o   (raw)
  );

  irq_cfg_regs #(.N(NUM_SRC)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .raw_i   (raw),
    .lvl_i   (lvl),
    .rdata_o (reg_rdata),
    .sense_o (sense),
    .dual_o  (dual),
    .pol_o   (pol),
    .route_o (route),
    .en_o    (en),
    .clr_o   (clr),
    .trig_o  (trig)
  );

  assign live  = raw & en;
  assign irq_o = |(live & ~route);
  assign fiq_o = |(live & route);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N = 51
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] raw,
  input logic [N-1:0] lvl,
  input logic [N-1:0] sense,
  input logic [N-1:0] pol,
  input logic [N-1:0] en,
  input logic [N-1:0] route,
  input logic [N-1:0] clr,
  input logic [N-1:0] trig,
  input logic [63:0]  rdata,
  input logic         irq,
  input logic         fiq
);
  // R3
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & $past(sense) & ~$past(trig)) == $past(~(lvl ^ pol) & sense & ~trig)));

  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(raw & ~sense & ~clr) & ~raw) == '0));

  // R7
  trig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(trig) & ~raw) == '0));

  // R8
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq && !fiq));

  // R9
  fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route == '0) |-> !fiq);

  // R9
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&route) |-> !irq);

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata >> N) == 64'd0));
endmodule

bind irq_sense_ctrl irq_ctrl_chk #(.N(NUM_SRC)) u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .raw   (raw),
  .lvl   (lvl),
  .sense (sense),
  .pol   (pol),
  .en    (en),
  .route (route),
  .clr   (clr),
  .trig  (trig),
  .rdata (reg_rdata),
  .irq   (irq_o),
  .fiq   (fiq_o)
);

// File: tb/tb_irq_sense_ctrl.sv
module tb_irq_sense_ctrl;
  localparam int unsigned NS = 51;
  localparam logic [63:0] MASK51 = (64'd1 << NS) - 64'd1;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          reg_we;
  logic [3:0]    reg_addr;
  logic [63:0]   reg_wdata;
  logic [63:0]   reg_rdata;
  logic          irq_o;
  logic          fiq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_sense_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Per-source configuration of sources 0..7: sense=i[0], dual=i[1], pol=i[2]
  function automatic logic [7:0] lvl_part(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (i[0]) r[i] = i[2] ? v[i] : ~v[i];
    return r;
  endfunction

  function automatic logic [7:0] edge_hits(input logic [7:0] vp, input logic [7:0] vn);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      logic ri = vn[i] & ~vp[i];
      logic fi = ~vn[i] & vp[i];
      if (!i[0]) r[i] = i[1] ? (ri | fi) : (i[2] ? ri : fi);
    end
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rv;
    logic [7:0]  vp, vn, exp_edge, exp_raw;
    rst_n = 1'b0; src = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {63'd0, irq_o}, 64'd0);
    chk("R1 fiq in reset", {63'd0, fiq_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd0, rv);  chk("R1 raw after reset", rv, 64'd0);
    rd(4'd3, rv);  chk("R1 sense after reset", rv, 64'd0);
    rd(4'd7, rv);  chk("R1 enable after reset", rv, 64'd0);
    rd(4'd12, rv); chk("R12 unmapped address reads 0", rv, 64'd0);

    // R11: upper bits ignore writes and read zero
    wr(4'd3, '1);
    rd(4'd3, rv); chk("R11 sense upper bits", rv, MASK51);
    wr(4'd6, '1);
    rd(4'd6, rv); chk("R11 route upper bits", rv, MASK51);
    wr(4'd6, 64'd0);

    // Configure sources 0..7 with all combinations, source 30 rising edge
    wr(4'd3, 64'hAA);
    wr(4'd4, 64'hCC);
    wr(4'd5, 64'hF0 | (64'd1 << 30));
    wr(4'd9, '1);
    @(negedge clk);
    rd(4'd9, rv); chk("R12 edge-clear reads 0", rv, 64'd0);
    vp = 8'h00; exp_edge = 8'h00;
    exp_raw = lvl_part(vp);
    rd(4'd0, rv); chk("R3 initial level sources", rv, {56'd0, exp_raw});

    // Sweep input patterns over the eight sense/dual/polarity combinations
    for (int s = 0; s < 32; s++) begin
      vn = 8'(s * 53 + 17) ^ 8'(s << 4);
      @(negedge clk);
      src[7:0] = vn;
      @(negedge clk);
      rd(4'd2, rv); chk("R2 level not yet visible", rv, {56'd0, vp});
      @(negedge clk);
      rd(4'd2, rv); chk("R2 level after two edges", rv, {56'd0, vn});
      rd(4'd0, rv); chk("R2 raw not yet updated", rv, {56'd0, lvl_part(vp) | exp_edge});
      @(negedge clk);
      exp_edge = exp_edge | edge_hits(vp, vn);
      exp_raw  = lvl_part(vn) | exp_edge;
      rd(4'd0, rv); chk("R4 R5 R3 raw after sweep step", rv, {56'd0, exp_raw});
      if (s[0]) begin
        wr(4'd9, 64'hFF);
        exp_edge = 8'h00;
        exp_raw  = lvl_part(vn);
        rd(4'd0, rv); chk("R6 R3 raw after clear", rv, {56'd0, exp_raw});
      end
      vp = vn;
    end

    // R8 enable set/clear behaviour
    wr(4'd7, 64'hFF);
    rd(4'd7, rv); chk("R8 enable set", rv, 64'hFF);
    wr(4'd7, 64'd0);
    rd(4'd8, rv); chk("R8 set with zeros no effect", rv, 64'hFF);
    wr(4'd8, 64'd0);
    rd(4'd7, rv); chk("R8 clear with zeros no effect", rv, 64'hFF);

    // R9/R10 sweep of enable and route masks
    for (int e = 0; e < 256; e += 17) begin
      for (int r = 0; r < 256; r += 51) begin
        logic [7:0] en8 = 8'(e);
        logic [7:0] rt8 = 8'(r);
        wr(4'd8, '1);
        wr(4'd7, {56'd0, en8});
        wr(4'd6, {56'd0, rt8});
        chk("R9 irq output", {63'd0, irq_o}, {63'd0, |(exp_raw & en8 & ~rt8)});
        chk("R9 fiq output", {63'd0, fiq_o}, {63'd0, |(exp_raw & en8 & rt8)});
        rd(4'd1, rv); chk("R10 pending", rv, {56'd0, exp_raw & en8});
      end
    end

    // R7 trigger on a disabled source, R8 raw updates but no output
    wr(4'd8, '1);
    wr(4'd10, 64'd1 << 20);
    rd(4'd0, rv); chk("R7 R8 trigger on disabled source", rv, {56'd0, exp_raw} | (64'd1 << 20));
    chk("R8 disabled source no irq", {63'd0, irq_o}, 64'd0);
    rd(4'd10, rv); chk("R12 trigger reads 0", rv, 64'd0);
    wr(4'd9, 64'd1 << 20);
    rd(4'd0, rv); chk("R6 clear of triggered bit", rv & (64'd1 << 20), 64'd0);

    // R6 edge coincides with clear: set wins
    wr(4'd10, 64'd1 << 30);
    @(negedge clk);
    src[30] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 64'd1 << 30;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(4'd0, rv); chk("R6 edge beats same-cycle clear", rv & (64'd1 << 30), 64'd1 << 30);
    wr(4'd9, 64'd1 << 30);
    rd(4'd0, rv); chk("R6 later clear removes bit", rv & (64'd1 << 30), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule